// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block collects 64 interrupt request lines and steers each one to one of two processor inputs: a fast-class output for the most urgent work and a normal-class output for everything else. Every source carries a programmable 3-bit level. Levels 0 and 1 belong to the fast class. Levels 2 to 7 belong to the normal class, and level 7 is the least urgent. A rising edge on a request line latches a pending flag. The block continuously picks the most urgent pending, enabled source of each class and signals it on that class's output line.

Software uses a simple 32-bit register port with a write strobe and a combinational read path. Through this port it enables sources, assigns their levels, and clears pending flags by writing ones. It can also read an entry word for each class. The entry word is the programmed base address plus four times one more than the winning source number, so a handler can index a table of entries directly from it. Sources are grouped into two 32-bit banks. Source `s` sits in bank `s/32` at bit `s%32`.

Top module: `dual_prio_intc`

## Requirements
- R1: After reset every pending flag, enable, level, control and base register reads 0, both outputs are low and both entry words read 0.
- R2: A pending flag is set only on a 0-to-1 change of its request line, sampled on the clock. A line held high does not set the flag again after it has been cleared.
- R3: Fast-status words (0x00 bank 0, 0x04 bank 1) show pending sources at levels 0–1. Normal-status words (0x08, 0x0C) show pending sources at levels 2–7. A 1 written to a status bit clears that pending flag only if the source belongs to that word's class. A 0 leaves the flag unchanged.
- R4: A request edge and a write-one clear of the same source in the same cycle leave the flag set.
- R5: The enable words (0x18 bank 0, 0x1C bank 1) are read/write. A disabled source never drives an output or an entry word, but its pending flag is kept. Clearing an enable bit removes the source's effect on the output one clock later.
- R6: The level words at 0x30+4n cover sources 8n..8n+7. Source 8n+k sits at bits [4k+2:4k]. Bit 4k+3 of each nibble reads 0.
- R7: A pending, enabled source at level 0–1 raises `irq_fast_o`. One at level 2–7 raises `irq_norm_o`.
- R8: Within a class, the winner is the lowest level. On equal levels the lowest source number wins.
- R9: The fast entry word (0x10) and the normal entry word (0x14) read base + 4*(winner+1). They read the base alone when the class has no pending, enabled source.
- R10: The outputs are registered levels. Each goes high one clock after its class gains an eligible source and low one clock after the class has none left.
- R11: The control word (0x20, 2 bits wide, upper bits read 0) and the base word (0x24, 32 bits) are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt request lines, one per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_fast_o | output | 1 | Fast-class interrupt output |
| irq_norm_o | output | 1 | Normal-class interrupt output |

## Verification
A request edge sets its pending flag at the first rising clock edge that sees it. Status and entry words show that flag right after that edge, and the class output follows one edge later. A register write takes effect at the edge on which the strobe is sampled, and an output change it causes shows one edge after that. The bench drives every input just after a falling edge and reads outputs half a period after the rising edge concerned. It waits one extra falling edge whenever an output register lies in the path.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC     = 64;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned LVL_W       = 3;
  localparam int unsigned FAST_LEVELS = 2;
  localparam int unsigned CTRL_W      = 2;

  // word indices (byte address / 4); bank offsets added per bank
  localparam int unsigned W_FSTAT = 0;
  localparam int unsigned W_NSTAT = 2;
  localparam int unsigned W_FENT  = 4;
  localparam int unsigned W_NENT  = 5;
  localparam int unsigned W_EN    = 6;
  localparam int unsigned W_CTRL  = 8;
  localparam int unsigned W_BASE  = 9;
  localparam int unsigned W_LVL   = 12;

  typedef enum logic {CLS_FAST = 1'b0, CLS_NORM = 1'b1} cls_e;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned N = intc_pkg::NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | rise;  // set beats clear
    end
  end

  assign pend_o = pend_q;

  assert_rise_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_o & $past(rise)) == $past(rise)));

  assert_set_over_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise & clr_i)) |=> ((pend_o & $past(rise & clr_i)) == $past(rise & clr_i)));

  assert_clr_works_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~rise)) |=> ((pend_o & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N  = intc_pkg::NUM_SRC,
  parameter int unsigned LW = intc_pkg::LVL_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         elig_i,
  input  logic [N-1:0][LW-1:0] lvl_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o,
  output logic [LW-1:0]        lvl_o
);
  // linear scan: strict compare keeps the lowest index on equal levels
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!hit_o || lvl_i[i] < lvl_o)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i];
      end
    end
  end

  assert_winner_elig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> elig_i[idx_o]);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_min_lvl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_i[i] |-> (hit_o && lvl_o <= lvl_i[i]));
    assert_tie_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_i[i] && lvl_i[i] == lvl_o) |-> (32'(idx_o) <= i));
  end
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned CW = CTRL_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [N-1:0]         pend_i,
  input  logic [1:0]           hit_i,
  input  logic [1:0][IW-1:0]   idx_i,
  output logic [N-1:0]         en_o,
  output logic [N-1:0][LW-1:0] lvl_o,
  output logic [N-1:0]         fast_o,
  output logic [N-1:0]         clr_o
);
  localparam int unsigned NBANK = N / DW;
  localparam int unsigned SLOT  = 4;
  localparam int unsigned PER   = DW / SLOT;
  localparam int unsigned NLVL  = N / PER;

  logic [31:0]          widx;
  logic [N-1:0]         en_q;
  logic [N-1:0][LW-1:0] lvl_q;
  logic [CW-1:0]        ctrl_q;
  logic [DW-1:0]        base_q;
  logic [1:0][DW-1:0]   ent;

  assign widx = 32'(addr_i >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      lvl_q  <= '0;
      ctrl_q <= '0;
      base_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NBANK; b++)
        if (widx == W_EN + b) en_q[b*DW +: DW] <= wdata_i;
      for (int r = 0; r < NLVL; r++)
        if (widx == W_LVL + r)
          for (int k = 0; k < PER; k++) lvl_q[r*PER + k] <= wdata_i[k*SLOT +: LW];
      if (widx == W_CTRL) ctrl_q <= wdata_i[CW-1:0];
      if (widx == W_BASE) base_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cls
    assign fast_o[i] = (lvl_q[i] < LW'(FAST_LEVELS));
  end

  assign en_o  = en_q;
  assign lvl_o = lvl_q;

  // write-one clear, filtered by the class of the status word
  always_comb begin
    clr_o = '0;
    if (we_i) begin
      for (int b = 0; b < NBANK; b++) begin
        if (widx == W_FSTAT + b) clr_o[b*DW +: DW] = wdata_i & fast_o[b*DW +: DW];
        if (widx == W_NSTAT + b) clr_o[b*DW +: DW] = wdata_i & ~fast_o[b*DW +: DW];
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ent
    assign ent[c] = hit_i[c] ? base_q + ((DW'(idx_i[c]) + DW'(1)) << 2) : base_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (widx == W_FSTAT + b) rdata_o = pend_i[b*DW +: DW] & fast_o[b*DW +: DW];
      if (widx == W_NSTAT + b) rdata_o = pend_i[b*DW +: DW] & ~fast_o[b*DW +: DW];
      if (widx == W_EN + b)    rdata_o = en_q[b*DW +: DW];
    end
    for (int r = 0; r < NLVL; r++)
      if (widx == W_LVL + r)
        for (int k = 0; k < PER; k++) rdata_o[k*SLOT +: LW] = lvl_q[r*PER + k];
    if (widx == W_CTRL) rdata_o = DW'(ctrl_q);
    if (widx == W_BASE) rdata_o = base_q;
    if (widx == W_FENT) rdata_o = ent[int'(CLS_FAST)];
    if (widx == W_NENT) rdata_o = ent[int'(CLS_NORM)];
  end

  assert_en_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == W_EN) |=> (en_o[DW-1:0] == $past(wdata_i)));

  assert_base_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == W_BASE) |=> (base_q == $past(wdata_i)));
endmodule

// File: rtl/dual_prio_intc.sv
module dual_prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_fast_o,
  output logic          irq_norm_o
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]         pend, en, fast, clr;
  logic [N-1:0][LW-1:0] lvl;
  logic [1:0][N-1:0]    elig;
  logic [1:0]           hit;
  logic [1:0][IW-1:0]   idx;
  logic [1:0][LW-1:0]   win_lvl;
  logic                 fast_q, norm_q;

  intc_pending #(.N(N)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(src_i), .clr_i(clr), .pend_o(pend)
  );

  intc_cfg #(.N(N), .DW(DW), .AW(AW), .LW(LW), .CW(CTRL_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .pend_i(pend), .hit_i(hit),
    .idx_i(idx), .en_o(en), .lvl_o(lvl), .fast_o(fast), .clr_o(clr)
  );

  for (genvar c = 0; c < 2; c++) begin : g_pick
    if (c == int'(CLS_FAST)) begin : g_f
      assign elig[c] = pend & en & fast;
    end else begin : g_n
      assign elig[c] = pend & en & ~fast;
    end
    intc_pick #(.N(N), .LW(LW)) u_pick (
      .clk_i(clk_i), .rst_ni(rst_ni), .elig_i(elig[c]), .lvl_i(lvl),
      .hit_o(hit[c]), .idx_o(idx[c]), .lvl_o(win_lvl[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      norm_q <= 1'b0;
    end else begin
      fast_q <= hit[int'(CLS_FAST)];
      norm_q <= hit[int'(CLS_NORM)];
    end
  end

  assign irq_fast_o = fast_q;
  assign irq_norm_o = norm_q;

  assert_fast_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fast_o |-> $past(|(pend & en & fast)));
  assert_norm_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_norm_o |-> $past(|(pend & en & ~fast)));
  assert_fast_lvl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[int'(CLS_FAST)] |-> (win_lvl[int'(CLS_FAST)] < LW'(FAST_LEVELS)));
  assert_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend & en)) |=> (!irq_fast_o && !irq_norm_o));
endmodule

// File: tb/sim_dual_prio_intc.sv
module sim_dual_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fq, nq;
  int          checks = 0;
  int          fails = 0;
  logic [2:0]  shl [64];
  logic [63:0] shen = '0;

  localparam logic [31:0] BASE = 32'h0000_1000;
  // {source, level}
  localparam int VEC [6][2] = '{'{0, 0}, '{5, 1}, '{31, 2}, '{32, 7}, '{63, 1}, '{40, 4}};

  always #5 clk = ~clk;

  dual_prio_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_fast_o(fq), .irq_norm_o(nq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(logic [63:0] m);
    @(negedge clk);
    src = src | m;
    @(negedge clk);
    src = src & ~m;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_lvl(int s, int l);
    logic [31:0] v;
    shl[s] = 3'(l);
    v = '0;
    for (int k = 0; k < 8; k++) v[k*4 +: 3] = shl[(s/8)*8 + k];
    wr(8'(32'h30 + 4*(s/8)), v);
  endtask

  task automatic put_en();
    wr(8'h18, shen[31:0]);
    wr(8'h1C, shen[63:32]);
  endtask

  task automatic clear_all();
    wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h0C, '1);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    finish_up();
  end

  initial begin
    int s, l;
    logic fast;
    logic [7:0] sa;
    for (int i = 0; i < 64; i++) shl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 fast out", {31'b0, fq}, 32'd0);
    chk("R1 norm out", {31'b0, nq}, 32'd0);
    rdchk("R1 en0", 8'h18, 0);
    rdchk("R1 en1", 8'h1C, 0);
    rdchk("R1 ctrl", 8'h20, 0);
    rdchk("R1 base", 8'h24, 0);
    rdchk("R1 lvl0", 8'h30, 0);
    rdchk("R1 lvl7", 8'h4C, 0);
    rdchk("R1 fent", 8'h10, 0);
    rdchk("R1 nent", 8'h14, 0);
    rdchk("R1 fstat", 8'h00, 0);
    rdchk("R1 nstat", 8'h08, 0);

    wr(8'h24, BASE);

    // table walk: routing, entry, status, clear
    for (int v = 0; v < 6; v++) begin
      s = VEC[v][0];
      l = VEC[v][1];
      fast = (l < 2);
      sa = 8'((fast ? 0 : 8) + 4*(s/32));
      shen = '0; shen[s] = 1'b1;
      put_en();
      set_lvl(s, l);
      pulse(64'd1 << s);
      settle();
      chk("R7 fast route", {31'b0, fq}, {31'b0, fast});
      chk("R7 norm route", {31'b0, nq}, {31'b0, ~fast});
      rdchk("R9 win entry", fast ? 8'h10 : 8'h14, BASE + 32'(4*(s+1)));
      rdchk("R9 idle entry", fast ? 8'h14 : 8'h10, BASE);
      rdchk("R3 status", sa, 32'd1 << (s % 32));
      wr(sa, 32'd1 << (s % 32));
      rdchk("R3 w1c", sa, 0);
      settle();
      chk("R10 fast drop", {31'b0, fq}, 0);
      chk("R10 norm drop", {31'b0, nq}, 0);
    end

    // R8 arbitration
    set_lvl(10, 3); set_lvl(20, 2); set_lvl(5, 2);
    set_lvl(40, 1); set_lvl(35, 1); set_lvl(50, 0);
    shen = '0;
    shen[5] = 1; shen[10] = 1; shen[20] = 1; shen[35] = 1; shen[40] = 1; shen[50] = 1;
    put_en();
    pulse(shen);
    settle();
    rdchk("R8 norm tie low idx", 8'h14, BASE + 32'(4*6));
    rdchk("R8 fast low level", 8'h10, BASE + 32'(4*51));
    wr(8'h08, 32'd1 << 5);
    rdchk("R8 norm next", 8'h14, BASE + 32'(4*21));
    wr(8'h08, 32'd1 << 20);
    rdchk("R8 norm level3", 8'h14, BASE + 32'(4*11));
    wr(8'h04, 32'd1 << 18);
    rdchk("R8 fast tie", 8'h10, BASE + 32'(4*36));
    wr(8'h04, '1);
    settle();
    chk("R10 fast cleared", {31'b0, fq}, 0);
    chk("R10 norm held", {31'b0, nq}, 1);

    // R5 enable gating
    shen[10] = 1'b0;
    wr(8'h18, shen[31:0]);
    settle();
    chk("R5 disable drops", {31'b0, nq}, 0);
    rdchk("R5 entry base", 8'h14, BASE);
    rdchk("R5 pend kept", 8'h08, 32'd1 << 10);
    set_lvl(12, 0);
    pulse(64'd1 << 12);
    settle(); settle();
    chk("R5 disabled silent", {31'b0, fq}, 0);
    shen[10] = 1'b1;
    put_en();
    settle();
    chk("R5 reenable", {31'b0, nq}, 1);
    clear_all();
    settle();
    chk("R10 all clear", {31'b0, nq}, 0);

    // R2 held line
    shen = '0; shen[3] = 1'b1;
    put_en();
    set_lvl(3, 0);
    @(negedge clk);
    src[3] = 1'b1;
    settle(); settle();
    chk("R2 edge sets", {31'b0, fq}, 1);
    wr(8'h00, 32'd1 << 3);
    settle(); settle();
    chk("R2 held no reset", {31'b0, fq}, 0);
    rdchk("R2 status", 8'h00, 0);
    src[3] = 1'b0;
    settle();

    // R4 set beats clear
    @(negedge clk);
    src[3] = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'd1 << 3;
    @(negedge clk);
    we = 1'b0;
    rdchk("R4 set wins", 8'h00, 32'd1 << 3);
    src[3] = 1'b0;

    // R3 zero write and wrong-class write
    wr(8'h00, 32'd0);
    rdchk("R3 zero keeps", 8'h00, 32'd1 << 3);
    wr(8'h08, 32'd1 << 3);
    rdchk("R3 class filter", 8'h00, 32'd1 << 3);
    wr(8'h00, 32'd1 << 3);
    rdchk("R3 cleared", 8'h00, 0);

    // R6 nibble layout: source 9 -> level 5
    wr(8'h34, 32'h0000_0050);
    shen = '0; shen[9] = 1'b1;
    put_en();
    pulse(64'd1 << 9);
    settle();
    chk("R6 norm class", {31'b0, nq}, 1);
    chk("R6 not fast", {31'b0, fq}, 0);
    rdchk("R6 entry", 8'h14, BASE + 32'(4*10));
    rdchk("R6 readback", 8'h34, 32'h0000_0050);
    wr(8'h30, '1);
    rdchk("R6 bit3 zero", 8'h30, 32'h7777_7777);
    clear_all();

    // R11 control and base
    wr(8'h20, '1);
    rdchk("R11 ctrl", 8'h20, 32'd3);
    rdchk("R11 base", 8'h24, BASE);

    finish_up();
  end
endmodule